// File: doc/BRIEF.md
# Two-Sided Mailbox Message Unit

This block passes 32-bit messages between two processors, called side A and side B, that share one clock. Each side has its own simple word-wide register bus with a write strobe, a read strobe, a byte address and a combinational read-data path. A side posts a message by writing one of its transmit registers. The message appears in the receive register of the same channel on the other side.

Every channel has a one-deep handshake. A transmit-empty flag tells the sender when it may write again. A receive-full flag tells the receiver that a message is waiting. Reading the receive register frees the slot.

A control register on each side holds interrupt enables, general-interrupt request bits and three free flag bits that the peer can see. Each side drives one level interrupt. The interrupt is raised by a waiting message, by a free transmit slot, or by a general request from the peer, whenever the matching enable is set.

Top module: `mbox_pair`

## Requirements
- R1: After reset, both status registers read 0x00F00000 (all transmit-empty flags set, nothing else), both control registers read 0, and both interrupt outputs are low.
- R2: Each side decodes word addresses only, with address bits 1:0 equal to 0; any access with nonzero low bits is ignored. The register layout is: transmit channel n at 0x00+4n, receive channel n at 0x10+4n, status at 0x20, control at 0x24.
- R3: A write to a side's transmit register n while its transmit-empty flag is set stores the message. On the next cycle, that side's transmit-empty flag (status bit 23-n) is clear. The peer's receive-full flag (status bit 27-n) is set, and the peer's receive register n returns the message. This holds in both directions.
- R4: Reading receive register n returns the message. From the next cycle, the reader's receive-full bit 27-n is clear and the sender's transmit-empty bit 23-n is set again.
- R5: A write to a transmit register whose transmit-empty flag is clear is ignored, and the message already held is delivered unchanged.
- R6: Channels are independent: reading one channel leaves the flags and data of the other channels unchanged.
- R7: Writing 1 to control bit 19-n on one side sets general-pending status bit 31-n on the peer. The request bits themselves read back as 0.
- R8: Writing 1 to a side's own status bit 31-n clears that pending bit. Writing 0 has no effect. If the peer requests the same bit in the same cycle, the pending bit stays set.
- R9: Control bits 31-n (general enable), 27-n (receive enable), 23-n (transmit enable) and 2:0 (flags) are stored and read back. All other control bits read 0. A side's flags appear in bits 2:0 of the peer's status register.
- R10: A side's interrupt output is high exactly when some channel has a set flag paired with a set enable. The pairs are receive-full with receive enable, transmit-empty with transmit enable, and general-pending with general enable.
- R11: Reading a receive register whose receive-full flag is clear changes no flag on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | AW | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational from a_addr |
| a_irq | output | 1 | Side A interrupt |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | AW | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational from b_addr |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench builds the block with its defaults: four channels and a six-bit address. This puts every reversed status and control position within reach, including channel 3 at bits 24, 20 and 28. Expected status words are worked out from the bit positions stated in the requirements. Traffic is run on channel pairs at both ends of the range, so a swapped or mirrored bit index shows up as a wrong status word.

// File: rtl/mbox_pair.sv
module mbox_pair #(
  parameter int NCH = 4,
  parameter int AW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr,
  input  logic          a_rd,
  input  logic [AW-1:0] a_addr,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_rdata,
  output logic          a_irq,
  input  logic          b_wr,
  input  logic          b_rd,
  input  logic [AW-1:0] b_addr,
  input  logic [31:0]   b_wdata,
  output logic [31:0]   b_rdata,
  output logic          b_irq
);
  localparam int DW  = 32;
  localparam int IW  = AW - 2;
  localparam int TXW = 0;
  localparam int RXW = 4;
  localparam int STW = 8;
  localparam int CRW = 9;

  function automatic logic [DW-1:0] ctl_mask();
    logic [DW-1:0] m = 'h7;
    for (int n = 0; n < NCH; n++) begin
      m[31-n] = 1'b1;
      m[27-n] = 1'b1;
      m[23-n] = 1'b1;
    end
    return m;
  endfunction
  localparam logic [DW-1:0] CMASK = ctl_mask();

  logic [1:0]          wr, rd, ok, st_wr, cr_wr, irq;
  logic [1:0][IW-1:0]  widx;
  logic [1:0][DW-1:0]  wdata, rdata, ctl, stat;
  logic [1:0][NCH-1:0] full, gp, tx_wr, rx_rd, gie, rie, tie;
  logic [DW-1:0]       msg [2][NCH];

  assign wr    = {b_wr, a_wr};
  assign rd    = {b_rd, a_rd};
  assign wdata = {b_wdata, a_wdata};
  assign widx  = {b_addr[AW-1:2], a_addr[AW-1:2]};
  assign ok    = {b_addr[1:0] == 2'b00, a_addr[1:0] == 2'b00};
  assign a_rdata = rdata[0];
  assign b_rdata = rdata[1];
  assign a_irq   = irq[0];
  assign b_irq   = irq[1];

  for (genvar s = 0; s < 2; s++) begin : g_side
    assign st_wr[s] = wr[s] && ok[s] && widx[s] == IW'(STW);
    assign cr_wr[s] = wr[s] && ok[s] && widx[s] == IW'(CRW);
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      assign tx_wr[s][n] = wr[s] && ok[s] && widx[s] == IW'(TXW + n);
      assign rx_rd[s][n] = rd[s] && ok[s] && widx[s] == IW'(RXW + n);
      assign gie[s][n]   = ctl[s][31-n];
      assign rie[s][n]   = ctl[s][27-n];
      assign tie[s][n]   = ctl[s][23-n];
    end

    always_comb begin
      stat[s] = '0;
      for (int n = 0; n < NCH; n++) begin
        stat[s][31-n] = gp[s][n];
        stat[s][27-n] = full[1-s][n];
        stat[s][23-n] = ~full[s][n];
      end
      stat[s][2:0] = ctl[1-s][2:0];
    end

    always_comb begin
      rdata[s] = '0;
      if (ok[s]) begin
        for (int n = 0; n < NCH; n++) begin
          if (widx[s] == IW'(TXW + n)) rdata[s] = msg[s][n];
          if (widx[s] == IW'(RXW + n)) rdata[s] = msg[1-s][n];
        end
        if (widx[s] == IW'(STW)) rdata[s] = stat[s];
        if (widx[s] == IW'(CRW)) rdata[s] = ctl[s];
      end
    end

    assign irq[s] = |(full[1-s] & rie[s]) | |(~full[s] & tie[s]) | |(gp[s] & gie[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= '0;
      gp   <= '0;
      ctl  <= '0;
      for (int s = 0; s < 2; s++)
        for (int n = 0; n < NCH; n++) msg[s][n] <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (cr_wr[s]) ctl[s] <= wdata[s] & CMASK;
        for (int n = 0; n < NCH; n++) begin
          if (st_wr[s] && wdata[s][31-n]) gp[s][n] <= 1'b0;
          if (rx_rd[s][n]) full[1-s][n] <= 1'b0;
        end
      end
      for (int s = 0; s < 2; s++) begin
        for (int n = 0; n < NCH; n++) begin
          if (cr_wr[1-s] && wdata[1-s][19-n]) gp[s][n] <= 1'b1;
          if (tx_wr[s][n] && !full[s][n]) begin
            full[s][n] <= 1'b1;
            msg[s][n]  <= wdata[s];
          end
        end
      end
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_chk
    for (genvar n = 0; n < NCH; n++) begin : g_chn
      p_tx_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr[s][n] && !full[s][n] |=> full[s][n] && msg[s][n] == $past(wdata[s]));
      p_rd_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd[1-s][n] && full[s][n] |=> !full[s][n]);
      p_drop_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr[s][n] && full[s][n] |=> $stable(msg[s][n]));
      p_gen_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cr_wr[s] && wdata[s][19-n] |=> gp[1-s][n]);
      p_gen_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr[s] && wdata[s][31-n] && !(cr_wr[1-s] && wdata[1-s][19-n]) |=> !gp[s][n]);
      p_empty_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd[1-s][n] && !full[s][n] && !tx_wr[s][n] |=> !full[s][n]);
    end
  end
endmodule

// File: tb/sim_mbox_pair.sv
module sim_mbox_pair;
  logic clk = 0, rst_n = 0;
  logic a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [5:0] a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0, a_rdata, b_rdata;
  logic a_irq, b_irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbox_pair u0 (.clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic bw(input bit s, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    if (s) begin b_wr = 1; b_addr = a; b_wdata = d; end
    else   begin a_wr = 1; a_addr = a; a_wdata = d; end
    @(negedge clk);
    a_wr = 0; b_wr = 0;
  endtask

  task automatic br(input bit s, input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    if (s) begin b_rd = 1; b_addr = a; end
    else   begin a_rd = 1; a_addr = a; end
    #1 d = s ? b_rdata : a_rdata;
    @(negedge clk);
    a_rd = 0; b_rd = 0;
  endtask

  task automatic peek(input bit s, input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    if (s) b_addr = a; else a_addr = a;
    #1 d = s ? b_rdata : a_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    peek(0, 6'h20, v); chk("R1 A status", v, 32'h00F00000);
    peek(1, 6'h20, v); chk("R1 B status", v, 32'h00F00000);
    peek(0, 6'h24, v); chk("R1 A ctrl", v, 0);
    peek(1, 6'h24, v); chk("R1 B ctrl", v, 0);
    chk("R1 irqs", {a_irq, b_irq}, 0);
  endtask

  task automatic t_a_to_b;
    logic [31:0] v;
    bw(0, 6'h04, 32'h1234ABCD);
    peek(0, 6'h20, v); chk("R3 A TE1 clear", v, 32'h00B00000);
    peek(1, 6'h20, v); chk("R3 B RF1 set", v, 32'h04F00000);
    br(1, 6'h14, v); chk("R4 B read data", v, 32'h1234ABCD);
    peek(1, 6'h20, v); chk("R4 B RF1 clear", v, 32'h00F00000);
    peek(0, 6'h20, v); chk("R4 A TE1 set", v, 32'h00F00000);
  endtask

  task automatic t_b_to_a;
    logic [31:0] v;
    bw(1, 6'h08, 32'h0000CAFE);
    peek(0, 6'h20, v); chk("R3 A RF2 set", v, 32'h02F00000);
    peek(1, 6'h20, v); chk("R3 B TE2 clear", v, 32'h00D00000);
    br(0, 6'h18, v); chk("R4 A read data", v, 32'h0000CAFE);
    peek(1, 6'h20, v); chk("R4 B TE2 set", v, 32'h00F00000);
  endtask

  task automatic t_full_drop;
    logic [31:0] v;
    bw(0, 6'h00, 32'h11);
    bw(0, 6'h00, 32'h22);
    br(1, 6'h10, v); chk("R5 held message", v, 32'h11);
  endtask

  task automatic t_channels;
    logic [31:0] v;
    bw(0, 6'h00, 32'hA0);
    bw(0, 6'h0C, 32'hA3);
    peek(1, 6'h20, v); chk("R6 B RF0,RF3", v, 32'h09F00000);
    peek(0, 6'h20, v); chk("R6 A TE0,TE3 clear", v, 32'h00600000);
    br(1, 6'h1C, v); chk("R6 ch3 data", v, 32'hA3);
    peek(1, 6'h20, v); chk("R6 B RF0 kept", v, 32'h08F00000);
    peek(0, 6'h20, v); chk("R6 A TE3 only", v, 32'h00700000);
    br(1, 6'h10, v); chk("R6 ch0 data", v, 32'hA0);
  endtask

  task automatic t_general;
    logic [31:0] v;
    bw(0, 6'h24, 32'h00080000);
    peek(1, 6'h20, v); chk("R7 B pending0", v, 32'h80F00000);
    peek(0, 6'h24, v); chk("R7 request reads 0", v, 0);
    peek(0, 6'h20, v); chk("R7 A untouched", v, 32'h00F00000);
    bw(1, 6'h20, 32'h40000000);
    peek(1, 6'h20, v); chk("R8 wrong bit kept", v, 32'h80F00000);
    bw(1, 6'h20, 32'h80000000);
    peek(1, 6'h20, v); chk("R8 cleared", v, 32'h00F00000);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    bw(0, 6'h24, 32'hFFFFFFFF);
    peek(0, 6'h24, v); chk("R9 A ctrl readback", v, 32'hFFF00007);
    peek(1, 6'h20, v); chk("R9 B sees flags, R7 all pending", v, 32'hF0F00007);
    chk("R10 A irq from TE", a_irq, 1);
    chk("R10 B irq off", b_irq, 0);
    bw(0, 6'h24, 32'h0);
    chk("R10 A irq off", a_irq, 0);
    bw(1, 6'h24, 32'h40000000);
    chk("R10 B irq general", b_irq, 1);
    bw(1, 6'h20, 32'hF0000000);
    chk("R10 B irq cleared", b_irq, 0);
    peek(1, 6'h20, v); chk("R8 all cleared", v, 32'h00F00000);
    bw(1, 6'h24, 32'h0);
  endtask

  task automatic t_rx_irq;
    logic [31:0] v;
    bw(1, 6'h24, 32'h08000000);
    chk("R10 B irq idle", b_irq, 0);
    bw(0, 6'h00, 32'h5A);
    chk("R10 B irq RF0", b_irq, 1);
    br(1, 6'h10, v); chk("R10 data", v, 32'h5A);
    chk("R10 B irq drop", b_irq, 0);
    bw(1, 6'h24, 32'h0);
  endtask

  task automatic t_misc;
    logic [31:0] v;
    br(0, 6'h1C, v);
    peek(0, 6'h20, v); chk("R11 A status", v, 32'h00F00000);
    peek(1, 6'h20, v); chk("R11 B status", v, 32'h00F00000);
    bw(0, 6'h01, 32'h77);
    peek(0, 6'h20, v); chk("R2 unaligned tx", v, 32'h00F00000);
    bw(0, 6'h26, 32'hFFFFFFFF);
    peek(0, 6'h24, v); chk("R2 unaligned ctrl", v, 0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_a_to_b;
    t_b_to_a;
    t_full_drop;
    t_channels;
    t_general;
    t_ctrl;
    t_rx_irq;
    t_misc;
    done = 1;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run;
    end
  end
endmodule